// File: doc/BRIEF.md
# Clock-Enable Configuration Write Port (I2C Block-Write Slave)

This block is a write-only two-wire serial slave that sets the output-enable bits and the spread-spectrum control of a clock generator. The bus master sends a block-write frame with these parts, in order:

- the device address with the write bit;
- a command byte;
- a byte count;
- one or more data bytes.

The slave acknowledges every byte of a frame that carries its address. It drops the command and count bytes. It writes the data bytes into the configuration registers, starting at register 0 and moving up one register per byte. Data bytes past the last register are acknowledged and then dropped.

SCL and SDA reach the block already synchronized to the system clock. The block oversamples them and finds start and stop conditions from SDA changes while SCL is high. A start in the middle of a frame begins a new frame. A stop after any whole byte ends the frame, and registers written so far keep their new values. The block drives SDA only through an open-drain enable (`sda_oe`, where 1 pulls the line low). It never stretches SCL, never answers the general call and never sends data.

Top module: `i2c_blkwr_cfg`

## Requirements
- R1: During and right after reset, the outputs are: `ss_en`=0, `usb48_en`=2'b11, `cpu2_en`=1, `sdram_en`=8'hFF, `pci_en`=7'h7F.
- R2: The address byte 8'hD2 (address 7'b1101001, bit 0 = write = 0) is acknowledged by pulling SDA low during the ninth SCL pulse. Any other address byte is not acknowledged, including read (8'hD3) and general call (8'h00). The slave then ignores the bus until the next start, and no register changes.
- R3: After an acknowledged address, every later byte of the frame is acknowledged. This covers the command byte, the count byte and each data byte, including data bytes beyond the last register.
- R4: The command byte and the count byte are not stored. The first data byte always goes to register 0, whatever their values.
- R5: Data byte k (counting from 0) goes to register k for k = 0, 1, 2. Later data bytes change no register.
- R6: A stop after any whole data byte ends the frame. Registers already written keep their new values, and the rest keep their old values.
- R7: Each byte is received MSB first. The first data bit on the bus becomes bit 7.
- R8: The register fields map to outputs as follows:
  - register 0 bit 3 → `ss_en`;
  - register 0 bits 2:1 → `usb48_en[1:0]`;
  - register 0 bit 0 → `cpu2_en`;
  - register 1 bits 7:0 → `sdram_en[7:0]`;
  - register 2 bits 7:1 → `pci_en[6:0]`.
- R9: A repeated start inside a frame restarts address matching, and the next data byte goes to register 0 again.
- R10: A data byte cut off by a stop before its eighth bit is not stored.
- R11: `sda_oe` changes only while SCL is low. It is released after the falling edge of the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA |
| ss_en | output | 1 | Spread-spectrum modulation enable |
| usb48_en | output | 2 | Enables of the two 48 MHz outputs |
| cpu2_en | output | 1 | Enable of CPU clock 2 |
| sdram_en | output | 8 | Enables of the SDRAM clock outputs |
| pci_en | output | 7 | Enables of PCI clocks 7..1 |

## Verification
The bench builds the block with its default device address 7'h69 and the package's three-register bank. It holds each SCL phase for four system clocks, so every edge is seen on distinct samples. Because the bank has only three registers, a five-byte frame reaches the drop-past-end path, and a one-byte frame with a nonzero command reaches the early-stop path. A nonmatching address, a read request and a general call each reach the ignore-until-start state. A repeated start and a stop after only three bits reach the restart and partial-byte paths.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int CFG_NUM_REGS = 3;
  localparam int CFG_IDX_W    = $clog2(CFG_NUM_REGS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_ACK, ST_SKIP} fsm_st_t;
  typedef enum logic [1:0] {BK_ADDR, BK_CMD, BK_CNT, BK_DATA} byte_kind_t;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = !scl_q && scl_i;
    scl_fall  = scl_q && !scl_i;
    start_det = scl_q && scl_i && sda_q && !sda_i;
    stop_det  = scl_q && scl_i && !sda_q && sda_i;
  end
endmodule

// File: rtl/i2c_frame_fsm.sv
module i2c_frame_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = CFG_NUM_REGS,
  parameter int         IDX_W    = CFG_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_bit,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);
  localparam logic [7:0]       ADDR_WR  = {DEV_ADDR, 1'b0};

  fsm_st_t          state;
  byte_kind_t       kind;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] data_idx;
  logic             bit_full;
  logic             addr_hit;

  assign bit_full = (bit_cnt == 4'd8);
  assign addr_hit = (shreg == ADDR_WR);

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= BK_ADDR;
      bit_cnt  <= '0;
      shreg    <= '0;
      data_idx <= '0;
      sda_oe   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else if (start_det) begin
      state    <= ST_SHIFT;
      kind     <= BK_ADDR;
      bit_cnt  <= '0;
      data_idx <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_SHIFT: begin
          if (scl_rise && !bit_full) begin
            shreg   <= {shreg[6:0], sda_bit};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_full) begin
            if (kind == BK_ADDR && !addr_hit) begin
              state <= ST_SKIP;
            end else begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
              case (kind)
                BK_ADDR: kind <= BK_CMD;
                BK_CMD:  kind <= BK_CNT;
                BK_CNT:  kind <= BK_DATA;
                default: begin
                  if (data_idx < LAST_IDX) begin
                    wr_en    <= 1'b1;
                    wr_idx   <= data_idx;
                    wr_data  <= shreg;
                    data_idx <= data_idx + 1'b1;
                  end
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state   <= ST_SHIFT;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_field_bank.sv
module cfg_field_bank
  import i2c_cfg_pkg::*;
#(
  parameter int IDX_W = CFG_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic             ss_en,
  output logic [1:0]       usb48_en,
  output logic             cpu2_en,
  output logic [7:0]       sdram_en,
  output logic [6:0]       pci_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_en    <= 1'b0;
      usb48_en <= 2'b11;
      cpu2_en  <= 1'b1;
      sdram_en <= 8'hFF;
      pci_en   <= 7'h7F;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_W'(0): begin
          ss_en    <= wr_data[3];
          usb48_en <= wr_data[2:1];
          cpu2_en  <= wr_data[0];
        end
        IDX_W'(1): sdram_en <= wr_data;
        IDX_W'(2): pci_en   <= wr_data[7:1];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_blkwr_cfg.sv
module i2c_blkwr_cfg
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       ss_en,
  output logic [1:0] usb48_en,
  output logic       cpu2_en,
  output logic [7:0] sdram_en,
  output logic [6:0] pci_en
);
  logic                 scl_rise, scl_fall, start_det, stop_det;
  logic                 wr_en;
  logic [CFG_IDX_W-1:0] wr_idx;
  logic [7:0]           wr_data;

  i2c_line_mon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_frame_fsm #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(CFG_NUM_REGS), .IDX_W(CFG_IDX_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_i),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_field_bank #(.IDX_W(CFG_IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ss_en(ss_en), .usb48_en(usb48_en), .cpu2_en(cpu2_en),
    .sdram_en(sdram_en), .pci_en(pci_en)
  );
endmodule

// File: rtl/i2c_blkwr_cfg_chk.sv
module i2c_blkwr_cfg_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe,
  input logic       ss_en,
  input logic [1:0] usb48_en,
  input logic       cpu2_en,
  input logic [7:0] sdram_en,
  input logic [6:0] pci_en
);
  logic [18:0] cfg_vec;
  assign cfg_vec = {ss_en, usb48_en, cpu2_en, sdram_en, pci_en};

  assert_reset_values_R1: assert property (@(posedge clk)
    rst |=> (cfg_vec == {1'b0, 2'b11, 1'b1, 8'hFF, 7'h7F}));

  assert_write_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_vec) |-> $past(sda_oe));

  assert_oe_steady_scl_high_R11: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_stop_releases_R11: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe);
endmodule

bind i2c_blkwr_cfg i2c_blkwr_cfg_chk u_chk (.*);

// File: tb/i2c_blkwr_cfg_tb.sv
module i2c_blkwr_cfg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe, ss_en, cpu2_en;
  logic [1:0] usb48_en;
  logic [7:0] sdram_en;
  logic [6:0] pci_en;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  logic [7:0] exp_r [0:2];
  logic [7:0] pl [0:7];
  bit    exp_q[$];
  string tag_q[$];
  event  ack_ev;

  localparam int PH = 4;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_blkwr_cfg u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .ss_en(ss_en), .usb48_en(usb48_en), .cpu2_en(cpu2_en),
    .sdram_en(sdram_en), .pci_en(pci_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected acknowledge per probed ninth clock
  initial begin
    forever begin
      @(ack_ev);
      if (exp_q.size() == 0) chk("R3 unexpected ack slot", 1, 0);
      else chk(tag_q.pop_front(), {31'd0, sda_oe}, {31'd0, exp_q.pop_front()});
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wt(PH); scl = 1'b1; wt(PH);
    sda_m = 1'b0; wt(PH); scl = 1'b0; wt(PH);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wt(PH); scl = 1'b1; wt(PH); sda_m = 1'b1; wt(PH);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(PH); scl = 1'b1; wt(PH); scl = 1'b0; wt(PH);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(PH); scl = 1'b1; wt(2);
    exp_q.push_back(exp_ack); tag_q.push_back(tag);
    -> ack_ev;
    wt(PH - 2); scl = 1'b0; wt(PH);
    chk("R11 sda released after ack clock", {31'd0, sda_oe}, 0);
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " R8 ss_en"},    {31'd0, ss_en},    {31'd0, exp_r[0][3]});
    chk({tag, " R8 usb48_en"}, {30'd0, usb48_en}, {30'd0, exp_r[0][2:1]});
    chk({tag, " R8 cpu2_en"},  {31'd0, cpu2_en},  {31'd0, exp_r[0][0]});
    chk({tag, " R8 sdram_en"}, {24'd0, sdram_en}, {24'd0, exp_r[1]});
    chk({tag, " R8 pci_en"},   {25'd0, pci_en},   {25'd0, exp_r[2][7:1]});
  endtask

  task automatic frame_body(input logic [7:0] cmd, input logic [7:0] cnt, input int n, input string tag);
    put_byte(8'hD2, 1'b1, {tag, " R2 addr ack"});
    put_byte(cmd, 1'b1, {tag, " R3 cmd ack"});
    put_byte(cnt, 1'b1, {tag, " R3 count ack"});
    for (int i = 0; i < n; i++) begin
      put_byte(pl[i], 1'b1, {tag, " R3 data ack"});
      if (i < 3) exp_r[i] = pl[i];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_r[0] = 8'h07; exp_r[1] = 8'hFF; exp_r[2] = 8'hFE;
    wt(5);
    check_regs("R1 in reset");
    rst = 1'b0;
    wt(3);
    check_regs("R1 after reset");
    chk("R1 sda_oe idle", {31'd0, sda_oe}, 0);

    // R4 R5 R7: three data bytes, nonzero command
    pl[0] = 8'h0A; pl[1] = 8'h01; pl[2] = 8'h54;
    i2c_start; frame_body(8'h5A, 8'd3, 3, "R5 full"); i2c_stop; wt(8);
    check_regs("R5 R7 full write");

    // R5: five bytes, two past the end dropped
    pl[0] = 8'h09; pl[1] = 8'hC3; pl[2] = 8'hAA; pl[3] = 8'h00; pl[4] = 8'h00;
    i2c_start; frame_body(8'h00, 8'd5, 5, "R5 overrun"); i2c_stop; wt(8);
    check_regs("R5 extra discarded");

    // R6 R4: stop after one byte, odd command and count
    pl[0] = 8'h06;
    i2c_start; frame_body(8'hFF, 8'd32, 1, "R6 short"); i2c_stop; wt(8);
    check_regs("R6 R4 early stop");

    // R2: wrong address, read request, general call
    i2c_start; put_byte(8'hA2, 1'b0, "R2 other addr nack");
    put_byte(8'h00, 1'b0, "R2 skip after nack"); put_byte(8'h00, 1'b0, "R2 skip after nack");
    put_byte(8'h00, 1'b0, "R2 skip after nack"); i2c_stop; wt(8);
    check_regs("R2 other addr");
    i2c_start; put_byte(8'hD3, 1'b0, "R2 read nack");
    put_byte(8'h00, 1'b0, "R2 skip"); put_byte(8'h01, 1'b0, "R2 skip");
    put_byte(8'h00, 1'b0, "R2 skip"); i2c_stop; wt(8);
    check_regs("R2 read");
    i2c_start; put_byte(8'h00, 1'b0, "R2 general call nack");
    put_byte(8'h00, 1'b0, "R2 skip"); put_byte(8'h01, 1'b0, "R2 skip");
    put_byte(8'h00, 1'b0, "R2 skip"); i2c_stop; wt(8);
    check_regs("R2 general call");

    // R9: repeated start mid-frame goes back to register 0
    pl[0] = 8'h0F; pl[1] = 8'h3C;
    i2c_start; frame_body(8'h00, 8'd3, 2, "R9 first");
    pl[0] = 8'h02;
    i2c_start; frame_body(8'h00, 8'd1, 1, "R9 second"); i2c_stop; wt(8);
    check_regs("R9 restart");

    // R10: byte cut after three bits is not stored
    pl[0] = 8'h08;
    i2c_start; frame_body(8'h00, 8'd2, 1, "R10 lead");
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    i2c_stop; wt(8);
    check_regs("R10 partial byte");

    wt(20);
    chk("R3 ack queue drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule